// File: doc/BRIEF.md
# Group-Windowed Control Memory Bridge

This block lets a 16-bit host bus reach a 32-bit wide control memory through a fixed 16 KiB address window. A 4-bit group register picks which 16 KiB region of the memory the window shows. The host can read the register, write it, or bump it by one through a dedicated strobe. Inside the window, every four consecutive host byte addresses map to one 32-bit memory word. The block turns each host byte or halfword access into a word address, a byte-enable mask and lane-aligned data for a simple synchronous memory port. On the way back it selects the requested lanes from the returned word.

The lowest 768 words of group 0 are write-protected. Host writes that land there are dropped before they reach the memory, but reads still work. Every host request receives a single-cycle acknowledge on the following clock, whatever the address. Addresses outside the window and the group register return zero and ignore writes.

Top module: `gwin_bridge`

## Requirements
- R1: `ack_o` is high in the cycle after every cycle in which `req_i` is high, and low in the cycle after every cycle in which `req_i` is low. This holds for any address.
- R2: The group register answers at host address 0xE834 (octal 164064) for byte or halfword accesses, and resets to 0. A write loads `wdata_i[3:0]`. A read returns the register zero-extended to 16 bits. A byte access at 0xE835 reads 0, and a write there does not change the register.
- R3: A pulse on `grp_inc_i` adds one to the group register modulo 16. If a host write to the register happens in the same cycle, the write wins. A host read in the same cycle returns the value before the update.
- R4: Host addresses 0x8000 to 0xBFFF form the window. The memory word index is {group, addr[13:2]}. `mem_req_o` is asserted, in the same cycle as `req_i`, only for window accesses; a write to a protected word (R9) is the exception and raises no request.
- R5: `size_i`=0 selects a byte access. Byte offset addr[1:0]=0 selects word bits 7:0, offset 1 selects bits 15:8, offset 2 selects bits 23:16 and offset 3 selects bits 31:24. Write data is taken from `wdata_i[7:0]`, and read data is returned zero-extended in `rdata_o[7:0]`.
- R6: `size_i`=1 at an even address is a halfword access. Offset 0 selects word bits 15:0 and offset 2 selects bits 31:16.
- R7: A halfword request at an odd address is carried out as a byte access at that address.
- R8: A write updates only the addressed bytes of a word; the other bytes of that word keep their contents.
- R9: Writes to word indices 0 to 767 of group 0 are ignored, and reads from those words return memory contents. Word 768 of group 0, and all words of other groups, accept writes.
- R10: Accesses outside the window and the group register return `rdata_o`=0 and have no effect. `rdata_o` is 0 whenever `ack_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access request, one cycle per access |
| we_i | input | 1 | Host write (1) or read (0) |
| size_i | input | 1 | 0 byte, 1 halfword |
| addr_i | input | 16 | Host byte address |
| wdata_i | input | 16 | Host write data (bytes in bits 7:0) |
| grp_inc_i | input | 1 | Increment the group register |
| ack_o | output | 1 | Access acknowledge, one cycle after request |
| rdata_o | output | 16 | Read data, valid with `ack_o` |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Memory write |
| mem_addr_o | output | 16 | Memory word index |
| mem_be_o | output | 4 | Byte enables for writes |
| mem_wdata_o | output | 32 | Lane-aligned write data |
| mem_rdata_i | input | 32 | Word read data, one cycle after `mem_req_o` |

## Verification
The hardest cases to reach are those where two effects meet in the same cycle or at a boundary. One is a host write to the group register arriving together with an increment pulse. Another is a read of the register during an increment. A third is a write straddling the edge of the protected range, at word 767 against word 768 of group 0. The stimulus issues back-to-back requests on every clock while pulsing the increment input against chosen accesses. It also moves the group to 15 and then 0 to cover the wrap and the protected region. Byte and halfword writes that land in the same words are read back to show that the other lanes were preserved. Reads under a different group show that the region really changed.

// File: rtl/gwb_pkg.sv
package gwb_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_MEM  = 2'd1,
    TGT_GRP  = 2'd2
  } tgt_e;
endpackage

// File: rtl/gwb_decode.sv
module gwb_decode
  import gwb_pkg::*;
#(
  parameter int HOST_AW    = 16,
  parameter int WIN_AW     = 14,
  parameter int GRP_W      = 4,
  parameter int PROT_WORDS = 768,
  parameter logic [HOST_AW-1:0] GRP_ADDR = 16'hE834,
  parameter logic [HOST_AW-WIN_AW-1:0] WIN_TAG = 2'b10,
  localparam int WORD_AW = WIN_AW - 2,
  localparam int MEM_AW  = GRP_W + WORD_AW
) (
  input  logic [HOST_AW-1:0] addr_i,
  input  logic               size_i,
  input  logic [GRP_W-1:0]   grp_i,
  output tgt_e               tgt_o,
  output logic [MEM_AW-1:0]  word_idx_o,
  output logic [1:0]         off_o,
  output logic               half_o,
  output logic               prot_o
);
  logic win_hit, grp_hit;

  assign win_hit    = addr_i[HOST_AW-1:WIN_AW] == WIN_TAG;
  assign grp_hit    = addr_i[HOST_AW-1:1] == GRP_ADDR[HOST_AW-1:1];
  assign word_idx_o = {grp_i, addr_i[WIN_AW-1:2]};
  assign off_o      = addr_i[1:0];
  // odd halfword degrades to byte
  assign half_o     = size_i & ~addr_i[0];
  assign prot_o     = (grp_i == '0) && (32'(addr_i[WIN_AW-1:2]) < PROT_WORDS);

  always_comb begin
    if (win_hit)      tgt_o = TGT_MEM;
    else if (grp_hit) tgt_o = TGT_GRP;
    else              tgt_o = TGT_NONE;
  end
endmodule

// File: rtl/gwb_group_reg.sv
module gwb_group_reg #(
  parameter int GRP_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [GRP_W-1:0] wdata_i,
  input  logic             inc_i,
  output logic [GRP_W-1:0] grp_o
);
  logic [GRP_W-1:0] grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    grp_q <= '0;
    else if (wr_i)  grp_q <= wdata_i;
    else if (inc_i) grp_q <= grp_q + 1'b1;
  end

  assign grp_o = grp_q;

  // R2
  grp_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> grp_o == $past(wdata_i));

  // R3
  grp_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !wr_i) |=> grp_o == GRP_W'($past(grp_o) + 1'b1));

  // R3
  grp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i) |=> $stable(grp_o));
endmodule

// File: rtl/gwb_lane.sv
module gwb_lane #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int WORD_W = LANES * BYTE_W,
  localparam int HALF_W = 2 * BYTE_W
) (
  input  logic [OFF_W-1:0]  off_i,
  input  logic              half_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [LANES-1:0]  be_o,
  output logic [WORD_W-1:0] wdata_o,
  input  logic [OFF_W-1:0]  roff_i,
  input  logic              rhalf_i,
  input  logic [WORD_W-1:0] rword_i,
  output logic [HALF_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] rbyte [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic [OFF_W-1:0]   LIDX = OFF_W'(l);
    localparam logic [OFF_W-2:0]   HIDX = (OFF_W-1)'(l / 2);
    assign be_o[l] = half_i ? (off_i[OFF_W-1:1] == HIDX) : (off_i == LIDX);
    assign wdata_o[l*BYTE_W +: BYTE_W] =
      half_i ? wdata_i[(l%2)*BYTE_W +: BYTE_W] : wdata_i[BYTE_W-1:0];
    assign rbyte[l] = rword_i[l*BYTE_W +: BYTE_W];
  end

  logic [OFF_W-1:0] lo_idx, hi_idx;
  assign lo_idx = {roff_i[OFF_W-1:1], 1'b0};
  assign hi_idx = {roff_i[OFF_W-1:1], 1'b1};

  always_comb begin
    if (rhalf_i) rdata_o = {rbyte[hi_idx], rbyte[lo_idx]};
    else         rdata_o = {{BYTE_W{1'b0}}, rbyte[roff_i]};
  end

  // R5 R6
  always_comb begin
    be_count_chk: assert ($countones(be_o) == (half_i ? 2 : 1));
  end
endmodule

// File: rtl/gwin_bridge.sv
module gwin_bridge
  import gwb_pkg::*;
#(
  parameter int HOST_AW    = 16,
  parameter int HOST_DW    = 16,
  parameter int MEM_DW     = 32,
  parameter int WIN_AW     = 14,
  parameter int GRP_W      = 4,
  parameter int PROT_WORDS = 768,
  parameter logic [HOST_AW-1:0] GRP_ADDR = 16'hE834,
  localparam int WORD_AW = WIN_AW - 2,
  localparam int MEM_AW  = GRP_W + WORD_AW,
  localparam int LANES   = MEM_DW / 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic               size_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [HOST_DW-1:0] wdata_i,
  input  logic               grp_inc_i,
  output logic               ack_o,
  output logic [HOST_DW-1:0] rdata_o,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [MEM_AW-1:0]  mem_addr_o,
  output logic [LANES-1:0]   mem_be_o,
  output logic [MEM_DW-1:0]  mem_wdata_o,
  input  logic [MEM_DW-1:0]  mem_rdata_i
);
  localparam logic [HOST_AW-WIN_AW-1:0] WIN_TAG = 2'b10;

  tgt_e              tgt;
  logic [MEM_AW-1:0] word_idx;
  logic [1:0]        off;
  logic              half, prot;
  logic [GRP_W-1:0]  grp;
  logic              grp_wr;

  gwb_decode #(
    .HOST_AW(HOST_AW), .WIN_AW(WIN_AW), .GRP_W(GRP_W),
    .PROT_WORDS(PROT_WORDS), .GRP_ADDR(GRP_ADDR), .WIN_TAG(WIN_TAG)
  ) u_decode (
    .addr_i(addr_i), .size_i(size_i), .grp_i(grp),
    .tgt_o(tgt), .word_idx_o(word_idx), .off_o(off),
    .half_o(half), .prot_o(prot)
  );

  assign grp_wr = req_i && we_i && (tgt == TGT_GRP) && !addr_i[0];

  gwb_group_reg #(.GRP_W(GRP_W)) u_grp (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(grp_wr),
    .wdata_i(wdata_i[GRP_W-1:0]), .inc_i(grp_inc_i), .grp_o(grp)
  );

  tgt_e             rsel_q;
  logic [1:0]       roff_q;
  logic             rhalf_q;
  logic [GRP_W-1:0] rgrp_q;
  logic             ack_q;
  logic [HOST_DW-1:0] lane_rdata;

  gwb_lane #(.LANES(LANES), .BYTE_W(8)) u_lane (
    .off_i(off), .half_i(half), .wdata_i(wdata_i),
    .be_o(mem_be_o), .wdata_o(mem_wdata_o),
    .roff_i(roff_q), .rhalf_i(rhalf_q), .rword_i(mem_rdata_i),
    .rdata_o(lane_rdata)
  );

  // protected writes never leave the block
  assign mem_req_o  = req_i && (tgt == TGT_MEM) && !(we_i && prot);
  assign mem_we_o   = mem_req_o && we_i;
  assign mem_addr_o = word_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q   <= 1'b0;
      rsel_q  <= TGT_NONE;
      roff_q  <= '0;
      rhalf_q <= 1'b0;
      rgrp_q  <= '0;
    end else begin
      ack_q   <= req_i;
      rsel_q  <= (req_i && !we_i) ? tgt : TGT_NONE;
      roff_q  <= off;
      rhalf_q <= half;
      rgrp_q  <= addr_i[0] ? '0 : grp;
    end
  end

  assign ack_o = ack_q;

  always_comb begin
    unique case (rsel_q)
      TGT_MEM: rdata_o = lane_rdata;
      TGT_GRP: rdata_o = {{(HOST_DW-GRP_W){1'b0}}, rgrp_q};
      default: rdata_o = '0;
    endcase
  end

  // R1
  ack_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ack_o);

  // R1
  ack_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !ack_o);

  // R4
  mem_req_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (req_i && addr_i[HOST_AW-1:WIN_AW] == WIN_TAG));

  // R9
  prot_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |->
      (mem_addr_o[MEM_AW-1:WORD_AW] != '0 ||
       32'(mem_addr_o[WORD_AW-1:0]) >= PROT_WORDS));

  // R10
  rdata_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> rdata_o == '0);
endmodule

// File: tb/gwin_bridge_tb_top.sv
module gwin_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0, sz = 1'b0, inc = 1'b0;
  logic [15:0] addr = '0, wdata = '0;
  logic        ack;
  logic [15:0] rdata;
  logic        mreq, mwe;
  logic [15:0] maddr;
  logic [3:0]  mbe;
  logic [31:0] mwdata;
  logic [31:0] mrdata = '0;

  always #5 clk = ~clk;

  gwin_bridge dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(sz),
    .addr_i(addr), .wdata_i(wdata), .grp_inc_i(inc),
    .ack_o(ack), .rdata_o(rdata), .mem_req_o(mreq), .mem_we_o(mwe),
    .mem_addr_o(maddr), .mem_be_o(mbe), .mem_wdata_o(mwdata),
    .mem_rdata_i(mrdata)
  );

  // far-side synchronous memory
  logic [31:0] mem_m [int];
  always @(posedge clk) begin
    if (mreq) begin
      logic [31:0] w;
      w = mem_m.exists(int'(maddr)) ? mem_m[int'(maddr)] : 32'h0;
      if (mwe) begin
        for (int b = 0; b < 4; b++) if (mbe[b]) w[b*8 +: 8] = mwdata[b*8 +: 8];
        mem_m[int'(maddr)] = w;
      end else begin
        mrdata <= w;
      end
    end
  end

  // reference model
  logic [7:0] ref_b [int];
  int         ref_grp = 0;
  bit         exp_ack = 0;
  logic [15:0] exp_rd = '0;
  string      prev_tag = "R1";
  int checks = 0, errors = 0;

  function automatic logic [7:0] rb(int k);
    return ref_b.exists(k) ? ref_b[k] : 8'h00;
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic step(bit rq, bit w, bit s, logic [15:0] a, logic [15:0] wd,
                      bit ic, string tag);
    bit mexp;
    int ng;
    @(negedge clk);
    chk(ack === exp_ack, "R1", {31'b0, ack}, {31'b0, exp_ack});
    chk(rdata === exp_rd, prev_tag, {16'b0, rdata}, {16'b0, exp_rd});
    exp_ack = rq;
    exp_rd  = '0;
    prev_tag = tag;
    mexp = 0;
    ng = ic ? (ref_grp + 1) % 16 : ref_grp;
    if (rq) begin
      int rel, key;
      bit half, prot;
      rel  = int'(a & 16'h3FFF);
      key  = ref_grp * 16384 + rel;
      half = s && !a[0];
      prot = (ref_grp == 0) && (rel / 4 < 768);
      if (a[15:14] == 2'b10) begin
        mexp = !(w && prot);
        if (!w) exp_rd = half ? {rb(key + 1), rb(key)} : {8'h00, rb(key)};
        else if (!prot) begin
          ref_b[key] = wd[7:0];
          if (half) ref_b[key + 1] = wd[15:8];
        end
      end else if ((a & 16'hFFFE) == 16'hE834) begin
        if (!w) exp_rd = a[0] ? 16'h0 : 16'(ref_grp);
        else if (!a[0]) ng = int'(wd[3:0]);
      end
    end
    ref_grp = ng;
    req = rq; we = w; sz = s; addr = a; wdata = wd; inc = ic;
    #1;
    chk(mreq === mexp, "R4", {31'b0, mreq}, {31'b0, mexp});
  endtask

  task automatic rd(logic [15:0] a, bit s, string tag);
    step(1, 0, s, a, 16'h0, 0, tag);
  endtask
  task automatic wr(logic [15:0] a, bit s, logic [15:0] d, string tag);
    step(1, 1, s, a, d, 0, tag);
  endtask
  task automatic idle();
    step(0, 0, 0, 16'h0, 16'h0, 0, "R10");
  endtask

  bit done = 0;
  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ack === 1'b0 && rdata === 16'h0, "R10", {15'b0, ack, rdata}, 32'h0);
    rst_n = 1'b1;
    idle();
    rd(16'hE834, 1, "R2");                  // reset group 0
    wr(16'hE834, 1, 16'h0005, "R2");
    rd(16'hE834, 1, "R2");
    // byte lanes, group 5
    wr(16'h8000, 0, 16'h0011, "R5");
    wr(16'h8001, 0, 16'h0022, "R5");
    wr(16'h8002, 0, 16'h0033, "R5");
    wr(16'h8003, 0, 16'h0044, "R5");
    rd(16'h8000, 1, "R6");
    rd(16'h8002, 1, "R6");
    rd(16'h8003, 0, "R5");
    rd(16'h8001, 0, "R5");
    // halfword and preservation
    wr(16'h8006, 1, 16'hBEEF, "R6");
    rd(16'h8004, 0, "R8");
    rd(16'h8007, 0, "R6");
    wr(16'h8005, 1, 16'h1277, "R7");
    rd(16'h8004, 1, "R7");
    rd(16'h8006, 1, "R8");
    rd(16'h8000, 1, "R8");
    // last word of the window
    wr(16'hBFFC, 1, 16'hCAFE, "R6");
    rd(16'hBFFD, 0, "R5");
    rd(16'hBFFE, 1, "R8");
    // another group shows another region
    wr(16'hE834, 1, 16'h0006, "R4");
    rd(16'h8000, 1, "R4");
    wr(16'h8000, 1, 16'h5A5A, "R4");
    wr(16'hE834, 0, 16'h0005, "R4");
    rd(16'h8000, 1, "R4");
    // outside the window
    wr(16'h4000, 1, 16'hFFFF, "R10");
    rd(16'h4000, 1, "R10");
    rd(16'hE836, 1, "R10");
    rd(16'hC000, 1, "R10");
    // odd group byte ignored
    wr(16'hE835, 0, 16'h000F, "R2");
    rd(16'hE835, 0, "R2");
    rd(16'hE834, 1, "R2");
    // increment and wrap
    wr(16'hE834, 1, 16'h000F, "R3");
    step(0, 0, 0, 16'h0, 16'h0, 1, "R3");
    rd(16'hE834, 1, "R3");
    step(1, 0, 1, 16'hE834, 16'h0, 1, "R3");   // read during increment: old value
    rd(16'hE834, 1, "R3");
    step(1, 1, 1, 16'hE834, 16'h0003, 1, "R3"); // write wins over increment
    rd(16'hE834, 1, "R3");
    step(1, 0, 1, 16'h8000, 16'h0, 1, "R3");    // access uses pre-increment group
    rd(16'hE834, 1, "R3");
    // protection in group 0
    wr(16'hE834, 1, 16'h0000, "R9");
    wr(16'h8000, 1, 16'h1111, "R9");
    rd(16'h8000, 1, "R9");
    wr(16'h8BFE, 1, 16'h2222, "R9");            // word 767
    rd(16'h8BFE, 1, "R9");
    wr(16'h8C00, 1, 16'h3333, "R9");            // word 768
    rd(16'h8C00, 1, "R9");
    wr(16'h8C03, 0, 16'h00AB, "R9");
    rd(16'h8C02, 1, "R9");
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule